// File: doc/BRIEF.md
# TFT Gate Line Scan Sequencer

This block is the digital core of a row driver for a thin-film-transistor panel. A single select token walks down a chain of 241 row stages, one stage per rising edge of the primary row clock. The token enters the first stage from the frame-start input. For every row, the block drives a 3-bit level-select code that the analog output stage uses to pick one of five rails. The rails are gate-high, positive pre-pulse, gate-low, negative pre-pulse and ground.

The panel uses gate-coupled storage capacitors, so the row after the selected one receives a pre-pulse. The row-inversion input sets the polarity of that pre-pulse. The selected row drives gate-high only while the secondary row clock is high, so adjacent rows never overlap at the high level. The 241st row exists only to pre-pulse the last display row and never drives gate-high. A programmable row count parks unused outputs at ground.

Both row clocks are treated as level inputs that are synchronous to the block clock `clk`. The shift happens on the `clk` edge that sees the primary row clock go from low to high.

Top module: `gate_line_sequencer`

## Requirements
- R1: While `rstN` is low, every row code is 000 (ground) and the select token is cleared. After release, no row is selected until a frame start is loaded.
- R2: The token moves by exactly one row only on a `clk` edge where `rowClkA` is high and was low at the previous edge. Holding `rowClkA` high for many cycles gives one step, and with `rowClkA` low the selection does not change.
- R3: On a shift edge where `frameStart` is high, row 1 becomes the only selected row and any older token is discarded. When `frameStart` is high without a shift edge, it is ignored.
- R4: The selected row drives 100 (gate-high) while `rowClkB` is high and 001 (gate-low) while it is low.
- R5: The row directly after the selected row drives 011 (positive pre-pulse) when `rowInv` is high and 010 (negative pre-pulse) when `rowInv` is low.
- R6: Every other active row drives 001 (gate-low). Row 1 never receives a pre-pulse.
- R7: Rows numbered above the effective count drive 000. The effective count is `rowCount`, except that 0 counts as 1 and values above 241 count as 241.
- R8: Row 241 never drives 100. When the token sits on row 241 it drives 001, and the token leaves the chain on the next shift.
- R9: Only the codes 000 to 100 appear on any row, and at most one row carries 100 at a time.
- R10: The codes are registered. The outputs present after a `clk` edge reflect the token after that edge, together with `rowClkB`, `rowInv` and `rowCount` as sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| rowClkA | input | 1 | Primary row clock; its rising edge advances the scan |
| rowClkB | input | 1 | Secondary row clock; high enables gate-high on the selected row |
| frameStart | input | 1 | Token input to row 1, sampled on a shift edge |
| rowInv | input | 1 | Pre-pulse polarity: 1 positive, 0 negative |
| rowCount | input | 8 | Number of active rows (0 counts as 1, above 241 counts as 241) |
| levelSel | output | 723 | Row codes, row k at bits [3k-1:3k-3]; 000 gnd, 001 low, 010 neg pre, 011 pos pre, 100 high |

## Verification
The hardest state to reach from the ports is the token sitting on row 241, and then leaving the chain. The stimulus must run a full frame of row periods with the count at its maximum, and alternate the polarity input on every row so that both pre-pulse codes are seen along the whole chain. The stimulus also restarts the frame in the middle of a scan, holds the primary row clock high for several cycles, and pulses frame start between shift edges. A reference model driven by a row index compares all 241 codes after every clock.

// File: rtl/gate_scan_pkg.sv
package gate_scan_pkg;

  typedef enum logic [2:0] {
    LVL_GND  = 3'b000,
    LVL_LOW  = 3'b001,
    LVL_NEG  = 3'b010,
    LVL_POS  = 3'b011,
    LVL_HIGH = 3'b100
  } level_e;

  // strobes from the control to the datapath, valid in the current clk cycle
  typedef struct packed {
    logic shiftEn;   // rising edge of the primary row clock seen this cycle
    logic loadBit;   // value entering row 1 on a shift
    logic gateOn;    // selected row may drive gate-high
    logic posPre;    // pre-pulse polarity
  } scan_ctrl_t;

endpackage

// File: rtl/gate_scan_ctrl.sv
module gate_scan_ctrl
  import gate_scan_pkg::*;
#(
  parameter int NROWS = 241,
  parameter int CW    = $clog2(NROWS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rowClkA,
  input  logic          rowClkB,
  input  logic          frameStart,
  input  logic          rowInv,
  input  logic [CW-1:0] rowCount,
  output scan_ctrl_t    strobe,
  output logic [CW-1:0] activeCount
);

  localparam logic [CW-1:0] MAX_COUNT = CW'(NROWS);

  logic prevA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevA <= 1'b0;
    else       prevA <= rowClkA;
  end

  always_comb begin
    strobe.shiftEn = rowClkA & ~prevA;
    strobe.loadBit = frameStart;
    strobe.gateOn  = rowClkB;
    strobe.posPre  = rowInv;
  end

  always_comb begin
    if (rowCount == '0)            activeCount = CW'(1);
    else if (rowCount > MAX_COUNT) activeCount = MAX_COUNT;
    else                           activeCount = rowCount;
  end

  // R2: a shift strobe cannot repeat on the next cycle without the clock dropping
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> !strobe.shiftEn);

  // R7: effective count stays within 1..NROWS
  a_r7_count_range: assert property (@(posedge clk) disable iff (!rstN)
    (activeCount != '0) && (activeCount <= MAX_COUNT));

endmodule

// File: rtl/gate_scan_datapath.sv
module gate_scan_datapath
  import gate_scan_pkg::*;
#(
  parameter int NROWS = 241,
  parameter int CW    = $clog2(NROWS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  scan_ctrl_t    strobe,
  input  logic [CW-1:0] activeCount,
  output level_e        levelQ [NROWS]
);

  logic [NROWS-1:0] tok;
  logic [NROWS-1:0] tokNext;
  logic [NROWS-1:0] isHigh;
  level_e           levelD [NROWS];

  always_comb begin
    if (!strobe.shiftEn)     tokNext = tok;
    else if (strobe.loadBit) tokNext = NROWS'(1);
    else                     tokNext = {tok[NROWS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tok <= '0;
    else       tok <= tokNext;
  end

  for (genvar i = 0; i < NROWS; i++) begin : g_row
    logic prevSel;
    logic rowActive;
    if (i == 0) begin : g_first
      assign prevSel = 1'b0;
    end else begin : g_rest
      assign prevSel = tokNext[i-1];
    end
    assign rowActive = (CW'(i) < activeCount);

    always_comb begin
      if (!rowActive)
        levelD[i] = LVL_GND;
      else if (tokNext[i])
        levelD[i] = (strobe.gateOn && (i != NROWS - 1)) ? LVL_HIGH : LVL_LOW;
      else if (prevSel)
        levelD[i] = strobe.posPre ? LVL_POS : LVL_NEG;
      else
        levelD[i] = LVL_LOW;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) levelQ[i] <= LVL_GND;
      else       levelQ[i] <= levelD[i];
    end

    assign isHigh[i] = (levelQ[i] == LVL_HIGH);

    // R9: never an undefined code
    a_r9_legal_code: assert property (@(posedge clk) disable iff (!rstN)
      levelQ[i] inside {LVL_GND, LVL_LOW, LVL_NEG, LVL_POS, LVL_HIGH});
  end

  // R9: at most one row at gate-high
  a_r9_one_high: assert property (@(posedge clk) disable iff (!rstN)
    $countones(isHigh) <= 1);

  // R8: extra row never drives gate-high
  a_r8_last_not_high: assert property (@(posedge clk) disable iff (!rstN)
    levelQ[NROWS-1] != LVL_HIGH);

  // R3: a load leaves exactly row 1 selected
  a_r3_load_single: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && strobe.loadBit) |=> (tok[0] && $countones(tok) == 1));

  // R2: without a shift strobe the token stays put
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(tok));

  // R1: outputs are ground while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_gnd: assert (isHigh == '0 && levelQ[0] == LVL_GND);
    end
  end

endmodule

// File: rtl/gate_line_sequencer.sv
module gate_line_sequencer
  import gate_scan_pkg::*;
#(
  parameter int NROWS = 241,
  parameter int CW    = $clog2(NROWS + 1),
  parameter int LW    = 3 * NROWS
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rowClkA,
  input  logic          rowClkB,
  input  logic          frameStart,
  input  logic          rowInv,
  input  logic [CW-1:0] rowCount,
  output logic [LW-1:0] levelSel
);

  scan_ctrl_t    strobe;
  logic [CW-1:0] activeCount;
  level_e        levelQ [NROWS];

  gate_scan_ctrl #(.NROWS(NROWS), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rowClkA     (rowClkA),
    .rowClkB     (rowClkB),
    .frameStart  (frameStart),
    .rowInv      (rowInv),
    .rowCount    (rowCount),
    .strobe      (strobe),
    .activeCount (activeCount)
  );

  gate_scan_datapath #(.NROWS(NROWS), .CW(CW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .activeCount (activeCount),
    .levelQ      (levelQ)
  );

  for (genvar i = 0; i < NROWS; i++) begin : g_pack
    assign levelSel[3*i +: 3] = levelQ[i];
  end

endmodule

// File: tb/sim_gate_line_sequencer.sv
module sim_gate_line_sequencer;

  localparam int CLK_P = 10;
  localparam int N     = 241;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         rowClkA = 1'b0;
  logic         rowClkB = 1'b0;
  logic         frameStart = 1'b0;
  logic         rowInv = 1'b0;
  logic [7:0]   rowCount = 8'd241;
  logic [3*N-1:0] levelSel;

  int vectors = 0;
  int errs = 0;
  int cyc = 0;
  bit started = 0;

  // behavioural reference: selected row index (0 = none)
  int mSel = 0;
  bit mPrevA = 0;
  int mExp [1:N];

  always #(CLK_P/2) clk = ~clk;

  gate_line_sequencer u0 (
    .clk(clk), .rstN(rstN), .rowClkA(rowClkA), .rowClkB(rowClkB),
    .frameStart(frameStart), .rowInv(rowInv), .rowCount(rowCount),
    .levelSel(levelSel)
  );

  function automatic string reqOf(int r, int e);
    if (!rstN) return "R1 reset";
    if (e == 0) return "R7 unused row";
    if (r == mSel) return (r == N) ? "R8 last row" : "R4 selected row";
    if (mSel != 0 && r == mSel + 1) return "R5 pre-pulse";
    return "R6 idle row";
  endfunction

  always @(posedge clk) begin
    int cntE;
    bit rise;
    cyc++;
    rise = rowClkA && !mPrevA;
    if (!rstN) begin
      mSel = 0; mPrevA = 0;
    end else begin
      if (rise) begin
        if (frameStart) mSel = 1;
        else if (mSel != 0) mSel = (mSel == N) ? 0 : mSel + 1;
      end
      mPrevA = rowClkA;
    end
    cntE = (rowCount == 0) ? 1 : ((rowCount > N) ? N : int'(rowCount));
    for (int r = 1; r <= N; r++) begin
      if (!rstN || r > cntE)                     mExp[r] = 0;
      else if (r == mSel)                        mExp[r] = (rowClkB && r != N) ? 4 : 1;
      else if (mSel != 0 && r == mSel + 1)       mExp[r] = rowInv ? 3 : 2;
      else                                       mExp[r] = 1;
    end
    #(CLK_P/4);
    if (started) begin
      int highs;
      bit bad;
      highs = 0; bad = 0;
      vectors++;
      for (int r = 1; r <= N; r++) begin
        int act;
        act = int'(levelSel[3*r-3 +: 3]);
        if (act == 4) highs++;
        if (act != mExp[r] && !bad) begin
          bad = 1;
          $display("FAIL %s row %0d: actual %0d expected %0d (R10 timing)",
                   reqOf(r, mExp[r]), r, act, mExp[r]);
        end
      end
      if (highs > 1) begin
        bad = 1;
        $display("FAIL R9 gate-high rows: actual %0d expected <=1", highs);
      end
      if (bad) errs++;
    end
    if (cyc > 200000) begin
      errs++;
      $display("FAIL watchdog: actual %0d cycles expected <=200000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  task automatic rowPeriod(input logic fs, input logic inv, input int gateCyc);
    @(negedge clk); rowClkA = 1; frameStart = fs; rowInv = inv; rowClkB = 0;
    @(negedge clk); rowClkA = 0; frameStart = 0;
    @(negedge clk); rowClkB = 1;
    repeat (gateCyc) @(negedge clk);
    rowClkB = 0;
    @(negedge clk);
  endtask

  initial begin
    started = 1;
    // R1: reset held
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);

    // full frame, polarity alternating: R2 R4 R5 R6 R8
    rowPeriod(1, 1, 3);
    for (int k = 0; k < N + 1; k++) rowPeriod(0, k[0], 2);

    // R7: short panel, then count 0 and over-range
    rowCount = 8'd5;
    rowPeriod(1, 0, 2);
    for (int k = 0; k < 6; k++) rowPeriod(0, 1, 2);
    rowCount = 8'd0;
    rowPeriod(1, 1, 2);
    rowPeriod(0, 0, 2);
    rowCount = 8'd250;
    rowPeriod(1, 0, 2);
    rowPeriod(0, 1, 2);

    // R3: restart mid-frame discards old token
    rowCount = 8'd241;
    for (int k = 0; k < 10; k++) rowPeriod(0, 0, 2);
    rowPeriod(1, 1, 2);
    rowPeriod(0, 0, 2);

    // R3/R2: frame start without a shift edge is ignored
    @(negedge clk); frameStart = 1;
    @(negedge clk); frameStart = 0;
    repeat (2) @(negedge clk);

    // R2: primary clock held high gives one step
    @(negedge clk); rowClkA = 1; rowClkB = 1;
    repeat (5) @(negedge clk);
    rowClkA = 0; rowClkB = 0;
    repeat (2) @(negedge clk);
    rowPeriod(0, 1, 2);

    // R1: reset mid-scan then resume
    @(negedge clk); rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    rowPeriod(0, 1, 2);
    rowPeriod(1, 0, 2);
    rowPeriod(0, 1, 2);
    repeat (2) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule